// File: doc/BRIEF.md
# Processor Cycle Counter with Control Register

This block keeps a 32-bit count of processor clock cycles and a small control register that governs it. Both sit behind one register port: a request with a write flag, a one-bit register select (0 selects the control register, 1 selects the counter), write data and combinational read data. The port also carries the requester's privilege level and a user-enable input. A control-register write from privilege level 0 without user enable is refused and flagged on a fault output in the same cycle.

The control register has five meaningful bit positions. Bit 0 enables counting. Bit 2 is an action bit that clears the count. Bit 3 selects the divide-by-64 prescale. Bit 4 is a spare storage bit with no function. Bit 5 prohibits counting. The counter advances only while enabled and not prohibited, either on every clock or once every 64 clocks. Software can read it at any time, load it whether it is running or frozen, and clear it. Changing the mode keeps every count already taken.

Top module: `cyc_ctr_unit`

## Requirements
- R1: After reset the control register reads 0 and the counter reads 0, so the counter is stopped.
- R2: A control write stores only bits 0, 3, 4 and 5 of the write data (mask 0x39). Every other bit reads back as 0.
- R3: A control write with bit 2 set clears the counter and the prescaler at that clock edge. Bit 2 is never stored and always reads 0.
- R4: The counter advances only while bit 0 is 1 and bit 5 is 0. Otherwise it holds its value.
- R5: With bit 3 set, a 6-bit prescaler advances on each clock while counting is allowed. The counter steps on the edge where the prescaler equals 63, which is once every 64 cycles.
- R6: A counter write (select 1) loads the write data at the next edge, whether the counter is frozen or running, and clears the prescaler. Counting then continues from the loaded value.
- R7: A control write at privilege level 0 while user enable is low raises fault_o in the request cycle and changes neither the control register nor the count. Reads and privileged or user-enabled writes do not fault.
- R8: At the edge that takes a control write, the counter still behaves under the previous settings. The new settings apply from the next edge on, and no accumulated count is lost.
- R9: The counter wraps from 0xFFFFFFFF to 0 and gives no overflow indication.
- R10: Read data reflects the selected register in the same cycle, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 1 | 0 = control register, 1 = counter |
| wdata_i | input | 32 | Write data |
| priv_lvl_i | input | 2 | Privilege level of the requester; 0 is unprivileged |
| user_en_i | input | 1 | Allows control writes at privilege level 0 |
| rdata_o | output | 32 | Read data of the selected register (combinational) |
| fault_o | output | 1 | Refused control write (combinational) |

## Verification
Read data and the fault flag are combinational, so the bench samples them a short delay after driving a request and before the next edge. Each write takes effect at the single rising edge that closes its request. The count after a write is therefore predicted by adding up exactly the edges the bench has let pass, noting that the write edge itself counts under the old settings. In divide mode the bench tracks the prescaler phase from its last clear, and it checks the count one edge before and at each 64-cycle step, including after switching modes mid-phase.

// File: rtl/cyc_ctr_pkg.sv
package cyc_ctr_pkg;
  localparam int unsigned CTL_E_BIT  = 0;
  localparam int unsigned CTL_C_BIT  = 2;
  localparam int unsigned CTL_D_BIT  = 3;
  localparam int unsigned CTL_X_BIT  = 4;
  localparam int unsigned CTL_DP_BIT = 5;
  localparam logic [31:0] CTL_WMASK  = 32'h0000_0039;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_CNT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic dp;
    logic x;
    logic d;
    logic e;
  } ctl_t;
endpackage

// File: rtl/cyc_ctl_reg.sv
module cyc_ctl_reg
  import cyc_ctr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctl_t              ctl_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q.e  <= wdata_i[CTL_E_BIT];
      ctl_q.d  <= wdata_i[CTL_D_BIT];
      ctl_q.x  <= wdata_i[CTL_X_BIT];
      ctl_q.dp <= wdata_i[CTL_DP_BIT];
    end
  end

  // action bit: acts on the write edge, never stored
  assign clr_o = we_i & wdata_i[CTL_C_BIT];

  always_comb begin
    rdata_o             = '0;
    rdata_o[CTL_E_BIT]  = ctl_q.e;
    rdata_o[CTL_D_BIT]  = ctl_q.d;
    rdata_o[CTL_X_BIT]  = ctl_q.x;
    rdata_o[CTL_DP_BIT] = ctl_q.dp;
  end

  assign ctl_o = ctl_q;

  // R2: write data lands masked
  a_r2_masked_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o == ($past(wdata_i) & DATA_W'(CTL_WMASK))));

  // R3: action bit always reads zero
  a_r3_c_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[CTL_C_BIT] == 1'b0);
endmodule

// File: rtl/cyc_prescale.sv
module cyc_prescale #(
  parameter int unsigned PRE_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_ONE  = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (run_i) pre_q <= pre_q + PRE_ONE;
  end

  assign tick_o = run_i & (pre_q == PRE_LAST);

  // R5: prescaler advances every allowed cycle
  a_r5_pre_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |=> (pre_q == $past(pre_q) + PRE_ONE));

  // R6: clear returns phase to zero
  a_r6_pre_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/cyc_count.sv
module cyc_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] ldata_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= ldata_i;
    else if (step_i) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cyc_ctr_unit.sv
module cyc_ctr_unit
  import cyc_ctr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 6,
  parameter int unsigned PRIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [PRIV_W-1:0] priv_lvl_i,
  input  logic              user_en_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              fault_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ctl_t             ctl;
  logic [CNT_W-1:0] ctl_rdata;
  logic [CNT_W-1:0] cnt;
  logic             ctl_req, ctl_we, cnt_we, c_clr;
  logic             run, pre_tick, step;

  assign ctl_req = req_i & wr_i & (reg_sel_e'(sel_i) == SEL_CTL);
  assign fault_o = ctl_req & (priv_lvl_i == '0) & ~user_en_i;
  assign ctl_we  = ctl_req & ~fault_o;
  assign cnt_we  = req_i & wr_i & (reg_sel_e'(sel_i) == SEL_CNT);

  cyc_ctl_reg #(.DATA_W(CNT_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we),
    .wdata_i (wdata_i),
    .ctl_o   (ctl),
    .clr_o   (c_clr),
    .rdata_o (ctl_rdata)
  );

  // current settings govern this edge; a control write applies afterwards
  assign run = ctl.e & ~ctl.dp;

  cyc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (c_clr | cnt_we),
    .tick_o (pre_tick)
  );

  assign step = run & (ctl.d ? pre_tick : 1'b1);

  cyc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (c_clr),
    .load_i  (cnt_we),
    .ldata_i (wdata_i),
    .step_i  (step),
    .cnt_o   (cnt)
  );

  assign rdata_o = (reg_sel_e'(sel_i) == SEL_CNT) ? cnt : ctl_rdata;

  // R4: stopped counter holds
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_we && !c_clr) |=> $stable(cnt));

  // R9: undivided counting steps by one, wrapping silently
  a_r9_step_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !ctl.d && !cnt_we && !c_clr) |=> (cnt == $past(cnt) + CNT_ONE));

  // R5: divided counting never jumps by more than one
  a_r5_div_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ctl.d && !cnt_we && !c_clr) |=>
      ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_ONE)));

  // R6: counter write loads the data
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we |=> (cnt == $past(wdata_i)));

  // R3: clear via control write
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_clr |=> (cnt == '0));

  // R7: refused write leaves control register untouched
  a_r7_fault_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> $stable(ctl_rdata));

  // R7: only control writes can fault
  a_r7_fault_only_ctl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (req_i && wr_i && !sel_i));
endmodule

// File: tb/cyc_ctr_unit_bench.sv
module cyc_ctr_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        sel_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  priv_lvl_i = 2'd3;
  logic        user_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic        fault_o;

  int checks = 0;
  int failures = 0;
  logic last_fault;
  logic [31:0] v;

  always #5 clk_i = ~clk_i;

  cyc_ctr_unit u_cyc_ctr_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .priv_lvl_i(priv_lvl_i), .user_en_i(user_en_i),
    .rdata_o(rdata_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one write; its effect appears at the single edge closing the request
  task automatic wr_reg(input logic s, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; wr_i = 1'b1; sel_i = s; wdata_i = d;
    #1 last_fault = fault_o;
    @(posedge clk_i);
    #1 req_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] r);
    req_i = 1'b1; wr_i = 1'b0; sel_i = s;
    #2 r = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pats [5];
    logic [31:0] base;
    int steps [3];
    int acc;
    pats[0] = 32'hA5A5_A5A5; pats[1] = 32'h5A5A_5A5A; pats[2] = 32'h0000_0010;
    pats[3] = 32'h0000_003F; pats[4] = 32'h0000_0024;
    steps[0] = 1; steps[1] = 3; steps[2] = 10;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    rd(1'b0, v); chk("R1 ctl after reset", v, 32'h0);
    rd(1'b1, v); chk("R1 cnt after reset", v, 32'h0);
    idle(5);
    rd(1'b1, v); chk("R4 disabled holds", v, 32'h0);

    // R2 masked control writes; none of these patterns runs the counter
    for (int i = 0; i < 5; i++) begin
      wr_reg(1'b0, pats[i]);
      rd(1'b0, v); chk("R2 ctl mask", v, pats[i] & 32'h39);
    end
    idle(7);
    rd(1'b1, v); chk("R4 prohibit or disable holds", v, 32'h0);

    // R6 load while frozen
    wr_reg(1'b1, 32'h1234);
    idle(4);
    rd(1'b1, v); chk("R6 frozen load", v, 32'h1234);

    // R4 run: write edge is still frozen, then one per edge
    wr_reg(1'b0, 32'h1);
    acc = 0;
    for (int i = 0; i < 3; i++) begin
      idle(steps[i]);
      acc += steps[i];
      rd(1'b1, v); chk("R4 counting", v, 32'h1234 + acc);
    end

    // R8 stop: write edge counts under old settings, then held
    wr_reg(1'b0, 32'h0);
    idle(9);
    rd(1'b1, v); chk("R8 stop keeps count", v, 32'h1243);
    rd(1'b1, v); chk("R10 read has no effect", v, 32'h1243);
    wr_reg(1'b0, 32'h1);
    idle(2);
    rd(1'b1, v); chk("R8 restart continues", v, 32'h1245);

    // R6 load while running
    wr_reg(1'b1, 32'h100);
    rd(1'b1, v); chk("R6 running load", v, 32'h100);
    idle(5);
    rd(1'b1, v); chk("R6 continues after load", v, 32'h105);

    // R9 wrap
    wr_reg(1'b1, 32'hFFFF_FFFE);
    idle(1);
    rd(1'b1, v); chk("R9 before wrap", v, 32'hFFFF_FFFF);
    idle(2);
    rd(1'b1, v); chk("R9 after wrap", v, 32'h1);

    // R3 clear while running
    wr_reg(1'b0, 32'h5);
    rd(1'b1, v); chk("R3 cleared", v, 32'h0);
    rd(1'b0, v); chk("R3 bit2 not stored", v, 32'h1);
    idle(6);
    rd(1'b1, v); chk("R3 counts after clear", v, 32'h6);

    // R7 refused write
    priv_lvl_i = 2'd0; user_en_i = 1'b0;
    wr_reg(1'b0, 32'h4);
    chk("R7 fault raised", {31'h0, last_fault}, 32'h1);
    rd(1'b0, v); chk("R7 ctl unchanged", v, 32'h1);
    idle(3);
    rd(1'b1, v); chk("R7 count not cleared", v, 32'd10);
    req_i = 1'b1; wr_i = 1'b0; sel_i = 1'b0;
    #1 chk("R7 read no fault", {31'h0, fault_o}, 32'h0);
    req_i = 1'b0;
    wr_reg(1'b1, 32'd10);
    chk("R7 cnt write no fault", {31'h0, last_fault}, 32'h0);
    user_en_i = 1'b1;
    wr_reg(1'b0, 32'h21);
    chk("R7 user enabled no fault", {31'h0, last_fault}, 32'h0);
    idle(4);
    rd(1'b1, v); chk("R7 user write applied", v, 32'd11);
    priv_lvl_i = 2'd3; user_en_i = 1'b0;

    // R5 divide by 64 from a clear
    wr_reg(1'b0, 32'hD);
    rd(1'b0, v); chk("R5 ctl readback", v, 32'h9);
    idle(63);
    rd(1'b1, v); chk("R5 one edge before step", v, 32'h0);
    idle(1);
    rd(1'b1, v); chk("R5 first step", v, 32'h1);
    idle(64 * 2 + 5);
    rd(1'b1, v); chk("R5 later steps", v, 32'h3);

    // R8 mode change mid-phase keeps count and prescaler phase
    wr_reg(1'b1, 32'h50);
    idle(10);
    rd(1'b1, v); chk("R5 no step mid phase", v, 32'h50);
    wr_reg(1'b0, 32'h1);
    rd(1'b1, v); chk("R8 divide off keeps count", v, 32'h50);
    idle(4);
    rd(1'b1, v); chk("R8 undivided after change", v, 32'h54);
    wr_reg(1'b0, 32'h9);
    base = 32'h55;
    idle(47);
    rd(1'b1, v); chk("R8 divide on keeps phase", v, base);
    idle(1);
    rd(1'b1, v); chk("R8 step at phase 63", v, base + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule